// File: doc/BRIEF.md
# Non-Uniform Segment Piecewise-Linear Function Evaluator

This block computes a fixed-point approximation of a one-variable function by splitting the input domain into segments of unequal width. Within each segment the function is replaced by a straight line, y = c1·x + c0. A breakpoint encoder compares the input against a stored, ascending list of boundaries and picks the segment. The segment number addresses a coefficient memory that holds one slope and intercept per segment. A multiply-add stage then rounds and saturates the result. Because the boundaries are free, narrow segments can be placed where the curve bends sharply and wide ones where it is nearly straight.

The input x is an unsigned fraction of XW bits (all bits fractional). Slopes, intercepts and the result are signed two's-complement values of CW bits that share one fixed-point format. The product c1·x carries XW more fractional bits than that format, and those bits are rounded away. Breakpoints and coefficient pairs are written through a single load port. Results come out of a fixed three-stage pipeline that accepts one input per clock.

Top module: `seg_lin_eval`

## Requirements
- R1: The segment index equals the number of stored breakpoints that are less than or equal to x, so an x exactly equal to a breakpoint belongs to the segment above it. With NBP breakpoints there are NBP+1 segments, numbered 0 to NBP.
- R2: For a segment with nonzero slope, out_y = floor((c1·x + 2^(XW-1)) / 2^XW) + c0, which rounds half toward plus infinity, using the pair stored for the selected segment.
- R3: For a segment whose stored slope is zero, out_y equals the stored c0 exactly, and the multiplier result is not used.
- R4: A sum above 2^(CW-1)-1 gives out_y = 2^(CW-1)-1, and a sum below -2^(CW-1) gives out_y = -2^(CW-1). The result never wraps.
- R5: out_valid is in_valid delayed by exactly three clocks. A new x is accepted on every clock, and every accepted x yields exactly one result.
- R6: A write with ld_we=1 and ld_sel=0 stores ld_bp as breakpoint number ld_addr (addresses NBP and above are dropped). A write with ld_sel=1 stores the pair (ld_c1, ld_c0) for segment ld_addr. A stored value changes only through such a write, and it applies to every x presented after the write cycle.
- R7: A write is ignored when in_valid is high or any pipeline stage holds a valid input in the same cycle.
- R8: Synchronous reset clears out_valid and out_y to 0 and sets every breakpoint to the all-ones value, so that only x = 2^XW-1 reaches segment NBP.
- R9: out_y holds its last result in every cycle in which out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | x is presented this cycle |
| in_x | input | XW | Unsigned fractional argument |
| ld_we | input | 1 | Write strobe for the load port |
| ld_sel | input | 1 | 0 = breakpoint write, 1 = coefficient pair write |
| ld_addr | input | IW | Breakpoint number or segment number |
| ld_bp | input | XW | Breakpoint value |
| ld_c1 | input | CW | Signed slope |
| ld_c0 | input | CW | Signed intercept |
| out_valid | output | 1 | out_y holds a new result |
| out_y | output | CW | Signed, rounded, saturated result |

## Verification
Each x that is accepted at a rising edge gets its result three edges later: one edge for the encoder register, one for the memory read and one for the multiply-add register. When the bench issues an input, it records the expected value together with the cycle counter plus three. A monitor samples on the falling edge and checks both the value and the arrival cycle of every output in issue order. The reset checks, the checks that a blocked write had no effect and the hold checks are made only after the pipeline has drained, so that no result still in flight can mask an effect.

// File: rtl/seg_lin_pkg.sv
package seg_lin_pkg;
  // Target selector on the load port.
  typedef enum logic {
    LD_BREAK = 1'b0,
    LD_COEF  = 1'b1
  } ld_kind_e;
endpackage

// File: rtl/seg_index_enc.sv
module seg_index_enc #(
  parameter int XW  = 12,
  parameter int NBP = 15,
  localparam int IW = $clog2(NBP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bp_we,
  input  logic [IW-1:0] bp_addr,
  input  logic [XW-1:0] bp_din,
  input  logic          in_valid,
  input  logic [XW-1:0] in_x,
  output logic          v_out,
  output logic [XW-1:0] x_out,
  output logic [IW-1:0] idx_out
);
  logic [XW-1:0] bp_q [NBP];
  logic [NBP-1:0] ge;

  for (genvar i = 0; i < NBP; i++) begin : g_bp
    always_ff @(posedge clk) begin
      if (rst)
        bp_q[i] <= '1;
      else if (bp_we && bp_addr == IW'(i))
        bp_q[i] <= bp_din;
    end

    assign ge[i] = (in_x >= bp_q[i]);

    // A breakpoint changes only through a write addressed to it.
    AST_BP_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
      !(bp_we && bp_addr == IW'(i)) |=> $stable(bp_q[i])); // R6
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_out   <= 1'b0;
      x_out   <= '0;
      idx_out <= '0;
    end else begin
      v_out   <= in_valid;
      x_out   <= in_x;
      idx_out <= IW'($countones(ge));
    end
  end
endmodule

// File: rtl/seg_coef_mem.sv
module seg_coef_mem #(
  parameter int IW = 4,
  parameter int DW = 32,
  localparam int DEPTH = 1 << IW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/seg_mac.sv
module seg_mac #(
  parameter int XW = 12,
  parameter int CW = 16,
  localparam int PW = CW + XW + 1,
  localparam int SW = CW + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          v_in,
  input  logic [XW-1:0] x,
  input  logic [CW-1:0] c1,
  input  logic [CW-1:0] c0,
  output logic          v_out,
  output logic [CW-1:0] y
);
  localparam logic signed [SW-1:0] SMAX = SW'((1 << (CW - 1)) - 1);
  localparam logic signed [SW-1:0] SMIN = -SMAX - SW'(1);
  localparam logic [PW:0] HALF = (PW + 1)'(1) << (XW - 1);

  logic signed [PW-1:0]    prod;
  logic signed [PW:0]      prod_r;
  logic signed [PW-XW:0]   q;
  logic signed [SW-1:0]    sum;
  logic        [CW-1:0]    sat;
  logic        [CW-1:0]    y_next;

  always_comb begin
    prod   = $signed(c1) * $signed({1'b0, x});
    prod_r = $signed({prod[PW-1], prod} + HALF);
    q      = prod_r[PW:XW];
    sum    = $signed({q[PW-XW], q}) + $signed({{(SW - CW){c0[CW-1]}}, c0});
    if (sum > SMAX)
      sat = SMAX[CW-1:0];
    else if (sum < SMIN)
      sat = SMIN[CW-1:0];
    else
      sat = sum[CW-1:0];
    // Zero slope: constant segment, multiplier path bypassed.
    y_next = (c1 == '0) ? c0 : sat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_out <= 1'b0;
      y     <= '0;
    end else begin
      v_out <= v_in;
      if (v_in)
        y <= y_next;
    end
  end

  AST_CONST_SEG: assert property (@(posedge clk) disable iff (rst)
    (v_in && c1 == '0) |=> (y == $past(c0))); // R3
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (v_in && !c1[CW-1] && !c0[CW-1]) |=> !y[CW-1]); // R4
endmodule

// File: rtl/seg_lin_eval.sv
module seg_lin_eval #(
  parameter int XW  = 12,
  parameter int CW  = 16,
  parameter int NBP = 15,
  localparam int IW = $clog2(NBP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [XW-1:0] in_x,
  input  logic          ld_we,
  input  logic          ld_sel,
  input  logic [IW-1:0] ld_addr,
  input  logic [XW-1:0] ld_bp,
  input  logic [CW-1:0] ld_c1,
  input  logic [CW-1:0] ld_c0,
  output logic          out_valid,
  output logic [CW-1:0] out_y
);
  import seg_lin_pkg::*;

  logic          v1, v2;
  logic [XW-1:0] x1, x2;
  logic [IW-1:0] idx1;
  logic [2*CW-1:0] coef_rd;
  logic          busy, ld_ok, bp_we, cf_we;
  logic [1:0]    age;

  assign busy  = in_valid | v1 | v2 | out_valid;
  assign ld_ok = ld_we & ~busy;
  assign bp_we = ld_ok & (ld_kind_e'(ld_sel) == LD_BREAK);
  assign cf_we = ld_ok & (ld_kind_e'(ld_sel) == LD_COEF);

  seg_index_enc #(.XW(XW), .NBP(NBP)) u_enc (
    .clk(clk), .rst(rst),
    .bp_we(bp_we), .bp_addr(ld_addr), .bp_din(ld_bp),
    .in_valid(in_valid), .in_x(in_x),
    .v_out(v1), .x_out(x1), .idx_out(idx1)
  );

  seg_coef_mem #(.IW(IW), .DW(2 * CW)) u_mem (
    .clk(clk), .we(cf_we), .waddr(ld_addr), .wdata({ld_c1, ld_c0}),
    .raddr(idx1), .rdata(coef_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v2 <= 1'b0;
      x2 <= '0;
    end else begin
      v2 <= v1;
      x2 <= x1;
    end
  end

  seg_mac #(.XW(XW), .CW(CW)) u_mac (
    .clk(clk), .rst(rst), .v_in(v2), .x(x2),
    .c1(coef_rd[2*CW-1:CW]), .c0(coef_rd[CW-1:0]),
    .v_out(out_valid), .y(out_y)
  );

  // Edges seen since reset, saturating; gates history-based checks.
  always_ff @(posedge clk) begin
    if (rst)
      age <= '0;
    else if (age != 2'd3)
      age <= age + 2'd1;
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && !out_valid) |-> $stable(out_y)); // R9
endmodule

// File: tb/seg_lin_eval_test.sv
module seg_lin_eval_test;
  localparam int XW = 12;
  localparam int CW = 16;
  localparam int NBP = 15;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [XW-1:0] in_x = '0;
  logic ld_we = 1'b0;
  logic ld_sel = 1'b0;
  logic [IW-1:0] ld_addr = '0;
  logic [XW-1:0] ld_bp = '0;
  logic [CW-1:0] ld_c1 = '0;
  logic [CW-1:0] ld_c0 = '0;
  logic out_valid;
  logic [CW-1:0] out_y;

  seg_lin_eval #(.XW(XW), .CW(CW), .NBP(NBP)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
    .ld_we(ld_we), .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_bp(ld_bp),
    .ld_c1(ld_c1), .ld_c0(ld_c0), .out_valid(out_valid), .out_y(out_y)
  );

  always #10 clk = ~clk; // 50 MHz

  localparam int BPV [NBP] = '{100, 180, 260, 400, 640, 900, 1200, 1500,
                               1750, 2000, 2400, 2800, 3200, 3600, 4000};
  localparam logic [XW-1:0] VX [16] = '{0, 99, 100, 101, 179, 180, 399, 400,
                                        1500, 2000, 2399, 3599, 3600, 3999, 4000, 4095};
  localparam int VSEG [16] = '{0, 0, 1, 1, 1, 2, 3, 4, 8, 10, 10, 13, 14, 14, 15, 15};

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int bc1 [16];
  int bc0 [16];
  int ey [256];
  int ecyc [256];
  string etag [256];
  int wrp = 0;
  int rdp = 0;
  int last_exp = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model(input int c1, input int c0, input int x);
    longint p;
    longint s;
    if (c1 == 0) return c0;
    p = longint'(c1) * x + 2048;
    p = p >>> 12;
    s = p + c0;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return int'(s);
  endfunction

  task automatic issue(input int x, input int exp, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_x = XW'(x);
    ey[wrp] = exp;
    ecyc[wrp] = cyc + 3;
    etag[wrp] = tag;
    wrp++;
    last_exp = exp;
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic load(input bit sel, input int addr, input int bp, input int c1, input int c0);
    @(negedge clk);
    ld_we = 1'b1;
    ld_sel = sel;
    ld_addr = IW'(addr);
    ld_bp = XW'(bp);
    ld_c1 = CW'(c1);
    ld_c0 = CW'(c0);
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  // Output monitor: value and arrival cycle, in issue order.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (rdp == wrp) begin
        chk(1'b0, "R5 unexpected output", int'($signed(out_y)), 0);
      end else begin
        chk(int'($signed(out_y)) == ey[rdp], etag[rdp], int'($signed(out_y)), ey[rdp]);
        chk(cyc == ecyc[rdp], "R5 latency", cyc, ecyc[rdp]);
        rdp++;
      end
    end
  end

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", cyc, 0);
      finish_up();
    end
  end

  initial begin
    for (int k = 0; k < 16; k++) begin
      bc1[k] = (k - 8) * 700;
      bc0[k] = k * 1500 - 11000;
    end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 valid after reset", int'(out_valid), 0);
    chk(out_y == '0, "R8 y after reset", int'($signed(out_y)), 0);

    // R8: reset breakpoints all ones -> only x=max reaches top segment
    load(1'b1, 0, 0, 0, 111);
    load(1'b1, 15, 0, 0, 222);
    issue(5, 111, "R8 reset bp low x");
    issue(4095, 222, "R8 reset bp max x");
    drain();

    // R6: program the table
    for (int k = 0; k < NBP; k++) load(1'b0, k, BPV[k], 0, 0);
    for (int k = 0; k < 16; k++) load(1'b1, k, 0, bc1[k], bc0[k]);

    // R1 R2 R3 R5: table walk, back to back; R7 writes attempted mid-stream
    for (int i = 0; i < 16; i++) begin
      issue(int'(VX[i]), model(bc1[VSEG[i]], bc0[VSEG[i]], int'(VX[i])),
            (VSEG[i] == 8) ? "R3 constant segment" : "R1 R2 table vector");
      if (i == 5) begin
        ld_we = 1'b1; ld_sel = 1'b1; ld_addr = 4'd8; ld_c1 = 16'd1000; ld_c0 = 16'd5;
      end else if (i == 7) begin
        ld_we = 1'b1; ld_sel = 1'b0; ld_addr = 4'd0; ld_bp = 12'hFFF;
      end else begin
        ld_we = 1'b0;
      end
    end
    drain();
    chk(rdp == wrp, "R5 one result per input", rdp, wrp);

    // R9: output holds after the stream
    chk(out_valid == 1'b0, "R9 valid low when idle", int'(out_valid), 0);
    chk(int'($signed(out_y)) == last_exp, "R9 y holds", int'($signed(out_y)), last_exp);

    // R7: blocked writes left coefficient 8 and breakpoint 0 untouched
    issue(1500, bc0[8], "R7 coef write blocked");
    issue(100, model(bc1[1], bc0[1], 100), "R7 bp write blocked");
    drain();

    // R4: saturation both ways
    load(1'b1, 15, 0, 32767, 32767);
    load(1'b1, 0, 0, -32768, -32768);
    issue(4095, 32767, "R4 saturate high");
    issue(99, -32768, "R4 saturate low");
    drain();

    // R2: rounding of exact halves
    load(1'b1, 10, 0, 3, 0);
    issue(2048, 2, "R2 round +1.5");
    drain();
    load(1'b1, 10, 0, -3, 0);
    issue(2048, -1, "R2 round -1.5");
    issue(2047, model(-3, 0, 2047), "R2 round below half");
    drain();

    // R6: breakpoint rewrite moves the boundary
    load(1'b0, 0, 50, 0, 0);
    issue(60, model(bc1[1], bc0[1], 60), "R6 new breakpoint");
    drain();

    chk(rdp == wrp, "R5 all results seen", rdp, wrp);
    done = 1'b1;
    finish_up();
  end
endmodule